// File: doc/BRIEF.md
# NVRAM Region Checksum Engine

This engine walks a region of a byte-wide, non-volatile memory, condenses it into a 16-bit checksum and writes that checksum back into the same memory. A controller pulses `go` together with a start address, a byte count and a destination address. The engine then takes over a synchronous single-port byte interface to the memory and raises `done` when the result is stored.

The checksum is not a bitwise shift-register code. Each step folds a 16-bit word into the running value using two nibbles of the difference between the running value and the word. Words are assembled big-endian from neighbouring bytes, and the word index advances by one byte, so successive words share a byte. When the count is odd, a final step uses the last byte as the upper half of a word whose lower half is zero. The engine fetches the bytes it needs once, in address order, and forms each overlapping word from the previous byte and the current byte.

Top module: `nvcs_engine`

## Requirements
- R1: After reset, `busy`, `done`, `mem_en` and `mem_we` are all low.
- R2: The running checksum starts at 0xFFFF. A byte count of zero stores 0xFFFF at the destination.
- R3: One step with running value p and word v computes d = p^v, a = d[3:0], b = d[7:4]^a, and next = (p>>8) ^ (a<<3) ^ (a<<8) ^ b ^ (b<<7) ^ (b<<12), kept to 16 bits. For example, with p = 0xFFFF and v = 0x0000 the result is 0x0F87.
- R4: A word takes the byte at the lower address as bits 15:8 and the byte at the next address as bits 7:0.
- R5: Let N be the count rounded down to even. The engine performs N steps, and step i uses the word that starts at byte start+i.
- R6: When the count is odd, one further step uses {byte at start+N, 8'h00}.
- R7: The result goes to the destination address with bits 15:8 first, and bits 7:0 go to the destination address plus one.
- R8: `done` is high for exactly one cycle. That cycle follows the clock edge that writes the second result byte, and `busy` is low in it.
- R9: A `go` pulse while `busy` is high has no effect. The run in progress finishes with its own parameters, and nothing is written at the second pulse's destination.
- R10: During a run the engine writes only the two destination bytes. Every other access is a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start pulse, sampled only when idle |
| start_addr | input | AW | First byte of the region |
| byte_count | input | AW+1 | Number of bytes in the region |
| dest_addr | input | AW | Where the 16-bit result is stored |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Write strobe, qualified by `mem_en` |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after the memory samples a read |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume the memory returns read data exactly one cycle after it samples a read strobe. They also assume that nothing else writes the memory while `busy` is high. The bench's behavioural RAM has that latency, and the bench writes memory contents only between runs. The engine reads one byte past the region (start+N when the count is even and nonzero), so the bench never places a destination that overlaps any byte a run reads. This keeps the expected checksum independent of the write-back.

// File: rtl/nvcs_pkg.sv
package nvcs_pkg;
  localparam int CSUM_W = 16;
  localparam logic [CSUM_W-1:0] CSUM_SEED = 16'hFFFF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DRAIN,
    ST_TAIL,
    ST_WR_HI,
    ST_WR_LO,
    ST_FIN
  } nvcs_state_t;
endpackage

// File: rtl/nvcs_fold.sv
module nvcs_fold
  import nvcs_pkg::*;
(
  input  logic [CSUM_W-1:0] acc_in,
  input  logic [CSUM_W-1:0] word_in,
  output logic [CSUM_W-1:0] acc_out
);
  logic [CSUM_W-1:0] diff;
  logic [3:0]        nib_lo;
  logic [3:0]        nib_mix;
  logic [CSUM_W-1:0] lo_ext;
  logic [CSUM_W-1:0] mix_ext;

  always_comb begin
    diff    = acc_in ^ word_in;
    nib_lo  = diff[3:0];
    nib_mix = diff[7:4] ^ nib_lo;
    lo_ext  = {12'h000, nib_lo};
    mix_ext = {12'h000, nib_mix};
    acc_out = (acc_in >> 8) ^ (lo_ext << 3) ^ (lo_ext << 8)
            ^ mix_ext ^ (mix_ext << 7) ^ (mix_ext << 12);
  end
endmodule

// File: rtl/nvcs_ctrl.sv
module nvcs_ctrl
  import nvcs_pkg::*;
#(
  parameter int AW = 10,
  localparam int CW = AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [AW-1:0]     start_addr,
  input  logic [CW-1:0]     byte_count,
  input  logic [AW-1:0]     dest_addr,
  input  logic [7:0]        mem_rdata,
  input  logic [CSUM_W-1:0] acc_next,
  output logic [CSUM_W-1:0] acc_q,
  output logic [CSUM_W-1:0] step_word,
  output logic              mem_en,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              busy,
  output logic              done
);
  nvcs_state_t   st;
  logic [AW-1:0] start_q, dest_q;
  logic          odd_q;
  logic [CW-1:0] rd_total_q, iss_cnt, rcv_cnt;
  logic          rd_v1, rd_v2;
  logic [7:0]    prev_q;
  logic [CW-1:0] fetch_total;

  // bytes to fetch: N+1 when any byte is needed, else none
  always_comb begin
    if (byte_count == '0) fetch_total = '0;
    else                  fetch_total = {byte_count[CW-1:1], 1'b0} + CW'(1);
  end

  assign step_word = (st == ST_TAIL) ? {prev_q, 8'h00} : {prev_q, mem_rdata};

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      start_q    <= '0;
      dest_q     <= '0;
      odd_q      <= 1'b0;
      rd_total_q <= '0;
      iss_cnt    <= '0;
      rcv_cnt    <= '0;
      rd_v1      <= 1'b0;
      rd_v2      <= 1'b0;
      prev_q     <= '0;
      acc_q      <= CSUM_SEED;
      mem_en     <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
    end else begin
      mem_en <= 1'b0;
      mem_we <= 1'b0;
      done   <= 1'b0;
      rd_v1  <= (st == ST_FETCH);
      rd_v2  <= rd_v1;

      if (rd_v2) begin
        prev_q  <= mem_rdata;
        rcv_cnt <= rcv_cnt + CW'(1);
        if (rcv_cnt != '0) acc_q <= acc_next;
      end

      unique case (st)
        ST_IDLE: begin
          if (go) begin
            start_q    <= start_addr;
            dest_q     <= dest_addr;
            odd_q      <= byte_count[0];
            rd_total_q <= fetch_total;
            iss_cnt    <= '0;
            rcv_cnt    <= '0;
            acc_q      <= CSUM_SEED;
            busy       <= 1'b1;
            st         <= (byte_count == '0) ? ST_WR_HI : ST_FETCH;
          end
        end
        ST_FETCH: begin
          mem_en   <= 1'b1;
          mem_addr <= start_q + iss_cnt[AW-1:0];
          iss_cnt  <= iss_cnt + CW'(1);
          if (iss_cnt == rd_total_q - CW'(1)) st <= ST_DRAIN;
        end
        ST_DRAIN: begin
          if (!rd_v1 && !rd_v2) st <= odd_q ? ST_TAIL : ST_WR_HI;
        end
        ST_TAIL: begin
          acc_q <= acc_next;
          st    <= ST_WR_HI;
        end
        ST_WR_HI: begin
          mem_en    <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= dest_q;
          mem_wdata <= acc_q[15:8];
          st        <= ST_WR_LO;
        end
        ST_WR_LO: begin
          mem_en    <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= dest_q + AW'(1);
          mem_wdata <= acc_q[7:0];
          st        <= ST_FIN;
        end
        ST_FIN: begin
          done <= 1'b1;
          busy <= 1'b0;
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  logic [AW-1:0] rd_ofs;
  assign rd_ofs = mem_addr - start_q;

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8
  done_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(mem_we) && !busy);
  // R10
  write_target_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_en && (mem_addr == dest_q || mem_addr == dest_q + AW'(1)));
  // R5
  read_window_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_en && !mem_we) |-> ({1'b0, rd_ofs} < rd_total_q));
  // R9
  go_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && go) |=> $stable(dest_q) && $stable(rd_total_q));
endmodule

// File: rtl/nvcs_engine.sv
module nvcs_engine
  import nvcs_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            go,
  input  logic [AW-1:0]   start_addr,
  input  logic [AW:0]     byte_count,
  input  logic [AW-1:0]   dest_addr,
  output logic            mem_en,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [7:0]      mem_wdata,
  input  logic [7:0]      mem_rdata,
  output logic            busy,
  output logic            done
);
  logic [CSUM_W-1:0] acc_q, acc_next, step_word;

  nvcs_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst(rst), .go(go),
    .start_addr(start_addr), .byte_count(byte_count), .dest_addr(dest_addr),
    .mem_rdata(mem_rdata), .acc_next(acc_next), .acc_q(acc_q),
    .step_word(step_word), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy), .done(done)
  );

  nvcs_fold u_fold (
    .acc_in(acc_q), .word_in(step_word), .acc_out(acc_next)
  );
endmodule

// File: tb/tb_nvcs_engine.sv
`timescale 1ns/1ps
module tb_nvcs_engine;
  localparam int AW = 10;
  localparam int MSZ = 1 << AW;

  logic clk = 1'b0, rst = 1'b1, go = 1'b0;
  logic [AW-1:0] start_addr = '0, dest_addr = '0;
  logic [AW:0]   byte_count = '0;
  logic mem_en, mem_we, busy, done;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic [7:0] ram [MSZ];

  int total = 0, bad = 0, cycles = 0;
  int exp_dest = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  nvcs_engine #(.AW(AW)) dut (
    .clk(clk), .rst(rst), .go(go), .start_addr(start_addr),
    .byte_count(byte_count), .dest_addr(dest_addr), .mem_en(mem_en),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      else        mem_rdata <= ram[mem_addr];
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // per-clock write monitor (R10)
  always @(negedge clk) begin
    cycles++;
    if (!rst && mem_en && mem_we)
      check(int'(mem_addr) == exp_dest || int'(mem_addr) == ((exp_dest + 1) % MSZ),
            "R10 write address", int'(mem_addr), exp_dest);
    if (cycles > 150000 && !finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic int step(input int p, input int v);
    int d, a, b;
    d = (p ^ v) & 16'hFFFF;
    a = d & 15;
    b = ((d >> 4) & 15) ^ a;
    return ((p >> 8) ^ (a << 3) ^ (a << 8) ^ b ^ (b << 7) ^ (b << 12)) & 16'hFFFF;
  endfunction

  function automatic int ref_csum(input int s, input int c);
    int acc = 16'hFFFF;
    int n = c & ~1;
    for (int i = 0; i < n; i++)
      acc = step(acc, (int'(ram[(s + i) % MSZ]) << 8) | int'(ram[(s + i + 1) % MSZ]));
    if (c & 1) acc = step(acc, int'(ram[(s + n) % MSZ]) << 8);
    return acc;
  endfunction

  task automatic run(input int s, input int c, input int d, input string req,
                     input bit extra_go, input int d2);
    int expv, t;
    expv = ref_csum(s, c);
    exp_dest = d;
    @(negedge clk);
    start_addr = AW'(s); byte_count = (AW+1)'(c); dest_addr = AW'(d); go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    if (extra_go) begin
      check(busy == 1'b1, {req, " busy during run"}, busy, 1);
      start_addr = AW'(s + 1); byte_count = (AW+1)'(c + 3); dest_addr = AW'(d2); go = 1'b1;
      @(negedge clk);
      go = 1'b0;
    end
    t = 0;
    while (!done && t < 5000) begin @(negedge clk); t++; end
    check(done == 1'b1, {req, " done seen"}, done, 1);
    check(busy == 1'b0, "R8 busy low with done", busy, 0);
    check(ram[d] == 8'(expv >> 8), {req, " high byte at dest"}, ram[d], (expv >> 8) & 255);
    check(ram[(d + 1) % MSZ] == 8'(expv), {req, " low byte at dest+1"}, ram[(d + 1) % MSZ], expv & 255);
    @(negedge clk);
    check(done == 1'b0, "R8 done single cycle", done, 0);
  endtask

  initial begin
    for (int i = 0; i < MSZ; i++) ram[i] = 8'((i * 37 + 11) & 255);
    repeat (3) @(negedge clk);
    check(!busy && !done && !mem_en && !mem_we, "R1 reset outputs",
          {busy, done, mem_en, mem_we}, 0);
    rst = 1'b0;
    @(negedge clk);
    run(10, 0, 600, "R2 zero count", 0, 0);
    check(ram[600] == 8'hFF && ram[601] == 8'hFF, "R2 seed 0xFFFF", {ram[600], ram[601]}, 16'hFFFF);
    ram[20] = 8'h00;
    run(20, 1, 610, "R6 single odd byte", 0, 0);
    check({ram[610], ram[611]} == 16'h0F87, "R3 known step value", {ram[610], ram[611]}, 16'h0F87);
    ram[30] = 8'h12; ram[31] = 8'hA5; ram[32] = 8'h3C;
    run(30, 2, 620, "R4 byte order", 0, 0);
    run(40, 7, 630, "R6 odd tail", 0, 0);
    run(100, 32, 640, "R5 overlapping words", 0, 0);
    run(200, 255, 650, "R5 long odd region", 0, 0);
    run(1000, 40, 660, "R5 address wrap", 0, 0);
    for (int i = 700; i < 704; i++) ram[i] = 8'h5A;
    run(300, 16, 670, "R9 ignored go", 1, 700);
    check(ram[700] == 8'h5A && ram[701] == 8'h5A, "R9 no write at second dest",
          {ram[700], ram[701]}, 16'h5A5A);
    run(64, 9, 680, "R7 placement", 0, 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule